// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a small counter that keeps a 4-bit value and steps it from two separate strobes. A rising edge on the up strobe adds one to the value, and a rising edge on the down strobe takes one away. Both strobes are asynchronous to the fast system clock that samples them. A parameter sets the count range: decimal (0 to 9, 8421 coding) or full binary (0 to 15). An active-high clear and an active-low preset load take effect whatever the strobes are doing, and clear wins over load.

Two active-low terminal outputs mirror the low phase of a strobe, and only at the terminal value. The carry output mirrors the up strobe while the count is at its maximum. The borrow output mirrors the down strobe while the count is zero. Because of this, each output can act as the count strobe of another counter.

A strobe may only step the count while the other strobe rests high. If both strobes rise in the same sampled cycle, nothing happens. This makes misuse of the strobes deterministic.

Top module: `dsc_counter`

## Requirements
- R1: A rising edge on `up_strobe` raises `count` by one, while `down_strobe` is high and clear and load are inactive. The new value appears on the third system clock edge after the strobe rises.
- R2: A rising edge on `down_strobe` lowers `count` by one, while `up_strobe` is high and clear and load are inactive. It has the same three-edge latency as R1.
- R3: With BCD_MODE=1, an up step from 9 gives 0 and a down step from 0 gives 9. With BCD_MODE=0, the same wrap happens between 15 and 0.
- R4: `clear`=1 makes `count` zero on the next clock edge, whatever `load_n`, `preset` and the strobes are doing.
- R5: With `clear`=0 and `load_n`=0, `count` takes `preset` on the next clock edge, even when a strobe is low.
- R6: `carry_n` is 0 only while `count` is at its maximum (9 in BCD mode, 15 in binary mode) and the synchronized up strobe is low. Otherwise it is 1.
- R7: `borrow_n` is 0 only while `count` is 0 and the synchronized down strobe is low. Otherwise it is 1.
- R8: With clear inactive, load inactive and both strobes held high, `count` does not change.
- R9: A strobe that is low during a clear or a load, and stays low after it, steps the count on its next rising edge.
- R10: Rising edges of both strobes in the same sampled cycle leave `count` unchanged.
- R11: A rising edge on one strobe is ignored while the other strobe is low.
- R12: In BCD mode, a preset of 10 to 15 is loaded as given. From such a value an up step gives 0 and a down step subtracts one.
- R13: After the system reset, `count` is 0 and `carry_n` and `borrow_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| up_strobe | input | 1 | Count-up strobe; acts on its rising edge |
| down_strobe | input | 1 | Count-down strobe; acts on its rising edge |
| load_n | input | 1 | Preset load, active low |
| clear | input | 1 | Clear to zero, active high, highest priority |
| preset | input | CNT_W | Value taken by a load |
| count | output | CNT_W | Current counter value |
| carry_n | output | 1 | Low while at maximum and the up strobe is low |
| borrow_n | output | 1 | Low while at zero and the down strobe is low |

## Verification
A strobe edge passes through two synchronizer flops and one edge-compare flop. The count therefore moves on the third clock edge after the strobe changes, and the bench samples it one falling edge later. In the latency test, the bench also confirms that the count has not yet moved after the second edge. `carry_n` and `borrow_n` depend on the synchronized strobe level, so they are checked two falling edges after the strobe changes. Clear and load are sampled at the next edge, and their results are checked at the falling edge that follows it.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   typedef enum logic [1:0] {
      DSC_HOLD = 2'd0,
      DSC_INC  = 2'd1,
      DSC_DEC  = 2'd2
   } dsc_op_e;
endpackage

// File: rtl/dsc_strobe_sync.sv
module dsc_strobe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic level,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dsc_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= strobe;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level = chain_q[STAGES-1];
   assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dsc_step.sv
module dsc_step
   import dsc_pkg::*;
#(
   parameter int unsigned CNT_W    = 4,
   parameter bit          BCD_MODE = 1'b1
) (
   input  logic [CNT_W-1:0] cur,
   input  dsc_op_e          op,
   output logic [CNT_W-1:0] nxt
);
   localparam logic [CNT_W-1:0] DEC_TOP = CNT_W'(9);

   if (BCD_MODE) begin : g_decimal
      always_comb begin
         unique case (op)
            DSC_INC: nxt = (cur >= DEC_TOP) ? '0 : cur + 1'b1;
            DSC_DEC: nxt = (cur == '0) ? DEC_TOP : cur - 1'b1;
            default: nxt = cur;
         endcase
      end
   end else begin : g_binary
      always_comb begin
         unique case (op)
            DSC_INC: nxt = cur + 1'b1;
            DSC_DEC: nxt = cur - 1'b1;
            default: nxt = cur;
         endcase
      end
   end
endmodule

// File: rtl/dsc_term.sv
module dsc_term #(
   parameter int unsigned      CNT_W   = 4,
   parameter logic [CNT_W-1:0] TOP_VAL = '1
) (
   input  logic [CNT_W-1:0] count,
   input  logic             up_lvl,
   input  logic             dn_lvl,
   output logic             carry_n,
   output logic             borrow_n
);
   assign carry_n  = ~((count == TOP_VAL) & ~up_lvl);
   assign borrow_n = ~((count == '0) & ~dn_lvl);
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter
   import dsc_pkg::*;
#(
   parameter int unsigned CNT_W       = 4,
   parameter bit          BCD_MODE    = 1'b1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_strobe,
   input  logic             down_strobe,
   input  logic             load_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam int unsigned      MODULUS = BCD_MODE ? 10 : (1 << CNT_W);
   localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(MODULUS - 1);

   if (BCD_MODE && CNT_W < 4) begin : g_bad_width
      $error("dsc_counter: decimal mode needs CNT_W >= 4");
   end

   logic    up_lvl, up_rise, dn_lvl, dn_rise;
   dsc_op_e op;
   logic [CNT_W-1:0] count_q, step_val;

   dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
      .clk(clk), .rst_n(rst_n), .strobe(up_strobe), .level(up_lvl), .rise(up_rise));
   dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
      .clk(clk), .rst_n(rst_n), .strobe(down_strobe), .level(dn_lvl), .rise(dn_rise));

   // a step is taken only when one strobe rises alone and the other rests high
   always_comb begin
      op = DSC_HOLD;
      if (up_rise && !dn_rise && dn_lvl)      op = DSC_INC;
      else if (dn_rise && !up_rise && up_lvl) op = DSC_DEC;
   end

   dsc_step #(.CNT_W(CNT_W), .BCD_MODE(BCD_MODE)) u_step (
      .cur(count_q), .op(op), .nxt(step_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           count_q <= '0;
      else if (clear)       count_q <= '0;
      else if (!load_n)     count_q <= preset;
      else if (op != DSC_HOLD) count_q <= step_val;
   end

   dsc_term #(.CNT_W(CNT_W), .TOP_VAL(TOP_VAL)) u_term (
      .count(count_q), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
      .carry_n(carry_n), .borrow_n(borrow_n));

   assign count = count_q;

   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count_q == '0));
   assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !load_n) |=> (count_q == $past(preset)));
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && !up_rise && !dn_rise) |=> $stable(count_q));
   assert_dual_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && up_rise && dn_rise) |=> $stable(count_q));
   assert_up_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && up_rise && !dn_lvl) |=> $stable(count_q));
   assert_up_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && up_rise && !dn_rise && dn_lvl) |=> (count_q != $past(count_q)));
   assert_dn_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load_n && dn_rise && !up_rise && up_lvl) |=> (count_q != $past(count_q)));
   assert_carry_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |-> (count_q == TOP_VAL && !up_lvl));
   assert_borrow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n |-> (count_q == '0 && !dn_lvl));
endmodule

// File: tb/dsc_counter_test.sv
module dsc_counter_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic up_s = 1'b1, dn_s = 1'b1, load_n = 1'b1, clr = 1'b0;
   logic [3:0] pre = 4'd0;
   logic [3:0] count;
   logic carry_n, borrow_n;
   int tests = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dsc_counter uut (
      .clk(clk), .rst_n(rst_n), .up_strobe(up_s), .down_strobe(dn_s),
      .load_n(load_n), .clear(clr), .preset(pre),
      .count(count), .carry_n(carry_n), .borrow_n(borrow_n));

   // table entry: {op[1:0], data[3:0], expected[3:0]}; op 0 load, 1 up, 2 down, 3 clear
   localparam logic [9:0] VEC [16] = '{
      {2'd3, 4'd0,  4'd0},  {2'd1, 4'd0,  4'd1},  {2'd1, 4'd0,  4'd2},  {2'd0, 4'd8,  4'd8},
      {2'd1, 4'd0,  4'd9},  {2'd1, 4'd0,  4'd0},  {2'd2, 4'd0,  4'd9},  {2'd2, 4'd0,  4'd8},
      {2'd0, 4'd0,  4'd0},  {2'd2, 4'd0,  4'd9},  {2'd0, 4'd12, 4'd12}, {2'd1, 4'd0,  4'd0},
      {2'd0, 4'd13, 4'd13}, {2'd2, 4'd0,  4'd12}, {2'd2, 4'd0,  4'd11}, {2'd3, 4'd0,  4'd0}
   };

   task automatic nwait(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_load(logic [3:0] v);
      pre = v; load_n = 1'b0; nwait(1); load_n = 1'b1;
   endtask
   task automatic do_clear();
      clr = 1'b1; nwait(1); clr = 1'b0;
   endtask
   task automatic up_step();
      up_s = 1'b0; nwait(2); up_s = 1'b1; nwait(3);
   endtask
   task automatic dn_step();
      dn_s = 1'b0; nwait(2); dn_s = 1'b1; nwait(3);
   endtask

   initial begin
      nwait(2);
      rst_n = 1'b1;
      nwait(1);
      chk("R13 count", count, 4'd0);
      chk("R13 carry_n", {3'b0, carry_n}, 4'd1);
      chk("R13 borrow_n", {3'b0, borrow_n}, 4'd1);

      // table walk: R1 R2 R3 R4 R5 R12
      for (int i = 0; i < 16; i++) begin
         case (VEC[i][9:8])
            2'd0: do_load(VEC[i][7:4]);
            2'd1: up_step();
            2'd2: dn_step();
            default: do_clear();
         endcase
         chk($sformatf("R1/R2/R3/R12 vector %0d", i), count, VEC[i][3:0]);
      end

      // R1 latency: unchanged after two edges, moved after the third
      do_load(4'd4);
      up_s = 1'b0; nwait(2); up_s = 1'b1;
      nwait(2); chk("R1 early", count, 4'd4);
      nwait(1); chk("R1 third edge", count, 4'd5);
      nwait(2);

      // R6 carry follows the up strobe low phase at the maximum
      do_load(4'd9);
      up_s = 1'b0; nwait(2);
      chk("R6 carry low", {3'b0, carry_n}, 4'd0);
      chk("R6 count held", count, 4'd9);
      up_s = 1'b1; nwait(2);
      chk("R6 carry high", {3'b0, carry_n}, 4'd1);
      nwait(1); chk("R3 wrap up", count, 4'd0);

      // R6 no carry below the maximum
      do_load(4'd8);
      up_s = 1'b0; nwait(2);
      chk("R6 no carry at 8", {3'b0, carry_n}, 4'd1);
      up_s = 1'b1; nwait(3);

      // R7 borrow at zero
      do_load(4'd0);
      dn_s = 1'b0; nwait(2);
      chk("R7 borrow low", {3'b0, borrow_n}, 4'd0);
      dn_s = 1'b1; nwait(2);
      chk("R7 borrow high", {3'b0, borrow_n}, 4'd1);
      nwait(1); chk("R3 wrap down", count, 4'd9);

      // R8 idle hold
      nwait(10); chk("R8 hold", count, 4'd9);

      // R4 clear beats load and strobes
      pre = 4'd5; load_n = 1'b0; clr = 1'b1; up_s = 1'b0;
      nwait(1); chk("R4 clear priority", count, 4'd0);
      clr = 1'b0; load_n = 1'b1;
      // R9 strobe low through clear counts on its next rise
      nwait(3); up_s = 1'b1; nwait(3);
      chk("R9 after clear", count, 4'd1);

      // R5 load while a strobe is low, then R9 after load
      dn_s = 1'b0; nwait(2);
      do_load(4'd7); chk("R5 load with strobe low", count, 4'd7);
      nwait(2); dn_s = 1'b1; nwait(3);
      chk("R9 after load", count, 4'd6);

      // R10 simultaneous rises
      up_s = 1'b0; dn_s = 1'b0; nwait(3);
      up_s = 1'b1; dn_s = 1'b1; nwait(4);
      chk("R10 dual edge", count, 4'd6);

      // R11 up rise ignored while down low; then down rise decrements
      dn_s = 1'b0; nwait(2);
      up_s = 1'b0; nwait(2); up_s = 1'b1; nwait(4);
      chk("R11 ignored", count, 4'd6);
      dn_s = 1'b1; nwait(3);
      chk("R2 down after release", count, 4'd5);

      // R12 preset 15 in decimal mode, down step
      do_load(4'd15); dn_step();
      chk("R12 down from 15", count, 4'd14);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule